// File: doc/BRIEF.md
# Bus-Attached Up/Down Counter Register

This block is one byte of storage that hangs off a shared data bus inside a processor datapath, for use as one half of a program counter, one half of an address register or as a stack pointer. On a rising clock edge it either copies the value present on the bus, or moves its stored value up or down by one, or keeps it. Independently of that, it can offer its stored value to the bus.

Real tri-state buffers are not used. The bus drive is split into a value output and a drive-enable output, and the surrounding bus logic merges these. A combinational wrap flag tells the surrounding logic, before the edge, that the step about to be taken will roll past either end of the range. That logic can use the flag to carry into or borrow from a neighbouring byte. Chaining two of these blocks into a 16-bit pair is done outside the block.

Top module: `updn_bus_reg`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the stored value becomes 0 after that edge, whatever the other inputs are.
- R2: `bus_drv` equals `oe` in the same cycle. `bus_out` carries the stored value while `oe` is 1 and is all zeros while `oe` is 0.
- R3: When `we` is 1 at a rising edge with reset inactive, the stored value becomes `bus_in` after that edge.
- R4: When `cnt_en` is 1, `we` is 0 and `dir_dn` is 0 at a rising edge, the stored value becomes its old value plus one, modulo 2^W (so 0xFF becomes 0x00).
- R5: When `cnt_en` is 1, `we` is 0 and `dir_dn` is 1 at a rising edge, the stored value becomes its old value minus one, modulo 2^W (so 0x00 becomes 0xFF).
- R6: When `we` and `cnt_en` are both 1 at the same edge, the load wins and no step is applied.
- R7: When both `we` and `cnt_en` are 0 at an edge, the stored value is unchanged.
- R8: `wrap` is 1 in a cycle exactly when `cnt_en` is 1 and either `dir_dn` is 0 with the value at all ones, or `dir_dn` is 1 with the value at zero. It is 0 whenever `cnt_en` is 0, and it does not depend on `we`.
- R9: `value` always shows the stored value. A change appears right after the clock edge that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_in | input | W | Value currently on the shared bus |
| oe | input | 1 | Request to put the stored value on the bus |
| we | input | 1 | Load the stored value from `bus_in` at the next edge |
| cnt_en | input | 1 | Step the stored value by one at the next edge |
| dir_dn | input | 1 | Step direction: 0 counts up, 1 counts down |
| bus_out | output | W | Value offered to the bus (zero when not driving) |
| bus_drv | output | 1 | Bus drive enable |
| value | output | W | Stored value |
| wrap | output | 1 | The step about to be taken will roll over |

## Verification
The `wrap`, `bus_drv` and `bus_out` results depend on the inputs and the present value in the same cycle. The effect of a load, a step or a reset appears on `value` one rising edge after the inputs that asked for it. The driver applies each set of inputs on the falling edge. It queues the expected combinational results for that cycle, together with the value the model holds before the coming edge, and then moves its model across the edge. The monitor compares two time units after each falling edge. At that point the outputs of the current cycle are settled and the previous edge has already updated `value`, so every result is compared in the cycle it is due.

// File: rtl/updn_bus_reg_pkg.sv
// Package: shared types for the bus-attached up/down counter register.
// Assumes: the action encoding is internal and is seen by no port.
package updn_bus_reg_pkg;

    // What the storage does at the next rising edge.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_INC  = 2'd2,
        ACT_DEC  = 2'd3
    } act_e;

    // Picks the action: a load outranks a step, and with no request the value holds.
    function automatic act_e pick_action(input logic we, input logic cnt_en, input logic dir_dn);
        act_e a;
        if (we)
            a = ACT_LOAD;
        else if (cnt_en)
            a = dir_dn ? ACT_DEC : ACT_INC;
        else
            a = ACT_HOLD;
        return a;
    endfunction

endpackage

// File: rtl/updn_bus_reg_step.sv
// Module: next-value logic. It turns the control inputs into one action and
// works out the value that the storage takes at the next edge.
// Assumes: the caller applies the reset; the arithmetic wraps modulo 2^W.
module updn_bus_reg_step
    import updn_bus_reg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] din,
    input  logic         we,
    input  logic         cnt_en,
    input  logic         dir_dn,
    output logic [W-1:0] nxt
);

    localparam logic [W-1:0] ONE = W'(1);

    act_e act;

    // Select the action for this cycle.
    always_comb act = pick_action(we, cnt_en, dir_dn);

    // Compute the candidate next value for the selected action.
    always_comb begin
        unique case (act)
            ACT_LOAD: nxt = din;
            ACT_INC:  nxt = cur + ONE;
            ACT_DEC:  nxt = cur - ONE;
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/updn_bus_reg_wrap.sv
// Module: roll-over detector. It raises its flag when the requested step will
// leave either end of the W-bit range at the next edge.
// Assumes: it does not look at a pending load; the flag only concerns stepping.
module updn_bus_reg_wrap #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  logic         cnt_en,
    input  logic         dir_dn,
    output logic         wrap
);

    localparam logic [W-1:0] TOP = {W{1'b1}};
    localparam logic [W-1:0] BOT = '0;

    logic at_top;
    logic at_bot;

    // Find out whether the value sits at either end of the range.
    always_comb begin
        at_top = (cur == TOP);
        at_bot = (cur == BOT);
    end

    // Raise the flag only while counting toward the end that the value sits at.
    always_comb wrap = cnt_en & (dir_dn ? at_bot : at_top);

endmodule

// File: rtl/updn_bus_reg_bus.sv
// Module: bus drive stage. It stands in for a tri-state buffer with a value
// output and a drive-enable output.
// Assumes: the bus fabric outside merges the drivers; the value is zero when not driving.
module updn_bus_reg_bus #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  logic         oe,
    output logic [W-1:0] bus_out,
    output logic         bus_drv
);

    // Gate the stored value with the enable so that an idle driver shows zeros.
    always_comb begin
        bus_drv = oe;
        bus_out = cur & {W{oe}};
    end

endmodule

// File: rtl/updn_bus_reg.sv
// Module: bus-attached up/down counter register (top). It stores W bits, loads
// from the bus, steps up or down, drives the bus on request and flags a roll-over one cycle ahead.
// Assumes: single clock; rst_n is synchronous and active low.
module updn_bus_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] bus_in,
    input  logic         oe,
    input  logic         we,
    input  logic         cnt_en,
    input  logic         dir_dn,
    output logic [W-1:0] bus_out,
    output logic         bus_drv,
    output logic [W-1:0] value,
    output logic         wrap
);

    logic [W-1:0] store_q;
    logic [W-1:0] store_d;

    updn_bus_reg_step #(.W(W)) u_step (
        .cur    (store_q),
        .din    (bus_in),
        .we     (we),
        .cnt_en (cnt_en),
        .dir_dn (dir_dn),
        .nxt    (store_d)
    );

    updn_bus_reg_wrap #(.W(W)) u_wrap (
        .cur    (store_q),
        .cnt_en (cnt_en),
        .dir_dn (dir_dn),
        .wrap   (wrap)
    );

    updn_bus_reg_bus #(.W(W)) u_bus (
        .cur     (store_q),
        .oe      (oe),
        .bus_out (bus_out),
        .bus_drv (bus_drv)
    );

    // Storage: clear it on reset, otherwise take the next value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            store_q <= '0;
        else
            store_q <= store_d;
    end

    // Show the stored value.
    assign value = store_q;

endmodule

// File: rtl/updn_bus_reg_chk.sv
// Module: property checker for updn_bus_reg, attached with the bind below.
// Assumes: it only observes the top-level ports.
module updn_bus_reg_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] bus_in,
    input logic         oe,
    input logic         we,
    input logic         cnt_en,
    input logic         dir_dn,
    input logic [W-1:0] bus_out,
    input logic         bus_drv,
    input logic [W-1:0] value,
    input logic         wrap
);

    // R2
    drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_drv == oe) && (oe || bus_out == '0) && (!oe || bus_out == value));

    // R3
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> value == $past(bus_in));

    // R4
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && cnt_en && !dir_dn) |=> value == W'($past(value) + W'(1)));

    // R5
    down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && cnt_en && dir_dn) |=> value == W'($past(value) - W'(1)));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && !cnt_en) |=> $stable(value));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |-> !wrap);

    // R8
    wrap_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> (dir_dn ? (value == '0) : (value == {W{1'b1}})));

endmodule

bind updn_bus_reg updn_bus_reg_chk #(.W(W)) u_chk (.*);

// File: tb/updn_bus_reg_bench.sv
// Scoreboard bench for updn_bus_reg: the driver queues expected results and the monitor compares them.
module updn_bus_reg_bench;

    localparam int W = 8;

    typedef struct {
        logic [W-1:0] val;
        logic         wrp;
        logic         drv;
        logic [W-1:0] bout;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] bus_in = '0;
    logic         oe = 1'b0, we = 1'b0, cnt_en = 1'b0, dir_dn = 1'b0;
    logic [W-1:0] bus_out, value;
    logic         bus_drv, wrap;

    int checks = 0;
    int errors = 0;
    exp_t sb[$];
    logic [W-1:0] model = '0;
    bit done = 0;

    always #4 clk = ~clk;  // 125 MHz

    updn_bus_reg #(.W(W)) u_updn_bus_reg (.*);

    // One check: counts it and prints a FAIL line on mismatch.
    task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: applies one cycle of inputs, queues the expected results, moves the model past the edge.
    task automatic drive(input bit rs, input bit w, input bit c, input bit dn, input bit o,
                         input logic [W-1:0] d, input bit push, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = rs; we = w; cnt_en = c; dir_dn = dn; oe = o; bus_in = d;
        if (push) begin
            e.val  = model;
            e.wrp  = c && (dn ? (model == '0) : (model == {W{1'b1}}));
            e.drv  = o;
            e.bout = o ? model : '0;
            e.tag  = tag;
            sb.push_back(e);
        end
        if (!rs)     model = '0;
        else if (w)  model = d;
        else if (c)  model = dn ? model - 1'b1 : model + 1'b1;
    endtask

    // Monitor: compares the queued expectations two time units after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(e.tag, "value", value, e.val);
                chk(e.tag, "wrap", W'(wrap), W'(e.wrp));
                chk(e.tag, "bus_drv", W'(bus_drv), W'(e.drv));
                chk(e.tag, "bus_out", bus_out, e.bout);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #100000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Stimulus
    initial begin
        drive(0, 0, 0, 0, 0, 8'h00, 0, "reset");
        drive(0, 0, 0, 0, 0, 8'h00, 0, "reset");
        drive(1, 0, 0, 0, 1, 8'h00, 1, "R1_reset_value");
        drive(1, 1, 0, 0, 0, 8'hFE, 1, "R3_load");
        drive(1, 0, 1, 0, 1, 8'h00, 1, "R4_inc_from_FE");
        drive(1, 0, 1, 0, 0, 8'h00, 1, "R8_wrap_up_at_FF");
        drive(1, 0, 1, 1, 1, 8'h00, 1, "R4_rollover_to_00_R8_wrap_down");
        drive(1, 0, 1, 1, 0, 8'h00, 1, "R5_rollover_to_FF");
        drive(1, 0, 0, 1, 1, 8'h55, 1, "R5_dec_to_FE_R7_hold");
        drive(1, 1, 1, 0, 0, 8'h10, 1, "R7_held_R6_load_vs_count");
        drive(1, 0, 0, 0, 1, 8'h00, 1, "R6_load_won_R2_drive");
        drive(1, 1, 0, 0, 0, 8'h00, 1, "R2_idle_bus_zero");
        drive(1, 0, 0, 1, 0, 8'h00, 1, "R8_no_wrap_when_disabled");
        drive(1, 1, 1, 1, 0, 8'hFF, 1, "R8_no_dep_on_we_R6");
        drive(1, 0, 1, 1, 1, 8'h00, 1, "R6_load_FF_not_dec");
        drive(1, 1, 0, 0, 0, 8'h80, 1, "R9_value_after_edge");
        drive(1, 0, 1, 0, 0, 8'h00, 1, "R9_loaded_80");
        drive(0, 1, 1, 0, 1, 8'h33, 1, "R1_reset_beats_load");
        drive(1, 0, 0, 0, 1, 8'h00, 1, "R1_cleared");
        drive(1, 0, 0, 0, 0, 8'h00, 1, "R7_final_hold");
        drive(1, 0, 0, 0, 0, 8'h00, 0, "drain");
        drive(1, 0, 0, 0, 0, 8'h00, 0, "drain");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule